// File: doc/BRIEF.md
# Burst Beat Address Generator

This block works out the byte address of every beat of a memory-mapped burst. Software-free and purely sequential, it takes a start address, a size code, a beat count and a burst type. It latches them on a one-cycle start pulse. It then presents one beat at a time on a valid/ready pair. Each beat carries its address, its index counted from zero, and a flag on the final beat.

Three burst types are supported. In a repeating burst every beat reuses the start address. In a stepping burst only the first beat may be misaligned, and later beats step from the size-aligned start. In a folding burst the address climbs in beat-sized steps inside a container of (bytes per beat × beat count) bytes. It returns to the container base when it reaches the container top. A request whose parameters are illegal produces no beats and only a one-cycle error pulse.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_valid_o`, `beat_last_o` and `err_o` are low.
- R2: A legal request on `start_i` while idle shows its first beat on the next cycle, with `beat_addr_o` equal to the start address and `beat_idx_o` equal to 0.
- R3: With `kind_i` = 2'b01 (stepping), beat 0 carries the start address exactly. Beat i > 0 carries (start rounded down to a multiple of 2**size) + i × 2**size, modulo 2**ADDR_W.
- R4: With `kind_i` = 2'b00 (repeating), every beat carries the unchanged start address, even when it is misaligned.
- R5: With `kind_i` = 2'b10 (folding), beat i carries base + ((start − base + i × 2**size) mod span). Here span = 2**size × beat count and base = start rounded down to a multiple of span.
- R6: A folding burst that starts on its container base yields the same address sequence as a stepping burst with the same fields.
- R7: Address, index and last flag advance only on a cycle where `beat_valid_o` and `beat_ready_i` are both high. Otherwise they hold.
- R8: `beat_last_o` is high exactly on the beat whose index is beat count − 1. After that beat is accepted, `beat_valid_o` is low on the next cycle.
- R9: A folding request whose start address is not a multiple of 2**size produces `err_o` high for the single cycle after the start pulse, and no beat.
- R10: A folding request whose beat count is not 2, 4, 8 or 16 produces the same error pulse and no beat.
- R11: A size code above MAX_SIZE (default 3), a beat count of 0, or `kind_i` = 2'b11 produces the same error pulse and no beat.
- R12: A start pulse while a burst is in progress is ignored: the running burst continues with its own addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| size_i | input | 3 | Log2 of bytes per beat |
| beats_i | input | LEN_W | Number of beats (length field plus one) |
| kind_i | input | 2 | 00 repeating, 01 stepping, 10 folding, 11 reserved |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| beat_addr_o | output | ADDR_W | Byte address of the current beat |
| beat_idx_o | output | LEN_W | Index of the current beat, from 0 |
| beat_last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
A wrong next-address calculation appears on `beat_addr_o` at the very next accepted beat. A wrong fold mask may stay hidden until the burst crosses its container top, so folding bursts that start in the middle and near the top of their container are run. A corrupted index or last-index register shows up as a mis-timed `beat_last_o`, or as `beat_valid_o` that stays high or drops one cycle early after the final handshake. A wrong legality decision shows up one cycle after the start pulse, as an error pulse together with, or instead of, a first beat.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  // Folding bursts may only span these beat counts.
  function automatic logic wrap_count_ok(input logic [31:0] cnt);
    return (cnt == 32'd2) || (cnt == 32'd4) || (cnt == 32'd8) || (cnt == 32'd16);
  endfunction

endpackage

// File: rtl/burst_check.sv
module burst_check
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 9,
  parameter int MAX_SIZE = 3
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size,
  input  logic [LEN_W-1:0]  beats,
  input  burst_kind_e       kind,
  output logic [ADDR_W-1:0] wrap_mask,
  output logic              legal,
  output logic              bad_align,
  output logic              bad_count,
  output logic              bad_field
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    low_mask  = (ONE << size) - ONE;
    wrap_mask = (ADDR_W'(beats) << size) - ONE;
    bad_align = (kind == BK_WRAP) && ((start_addr & low_mask) != '0);
    bad_count = (kind == BK_WRAP) && !wrap_count_ok(32'(beats));
    bad_field = (32'(size) > MAX_SIZE) || (beats == '0) || (kind == BK_RSVD);
    legal     = !(bad_align || bad_count || bad_field);
  end

endmodule

// File: rtl/burst_next.sv
module burst_next
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  burst_kind_e       kind,
  input  logic [ADDR_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] next_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] step_incr(input logic [ADDR_W-1:0] a,
                                                  input logic [2:0] sz);
    logic [ADDR_W-1:0] stride;
    stride = ONE << sz;
    return (a & ~(stride - ONE)) + stride;
  endfunction

  function automatic logic [ADDR_W-1:0] step_wrap(input logic [ADDR_W-1:0] a,
                                                  input logic [2:0] sz,
                                                  input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] stride;
    stride = ONE << sz;
    return (a & ~m) | ((a + stride) & m);
  endfunction

  always_comb begin
    unique case (kind)
      BK_INCR: next_addr = step_incr(cur_addr, size);
      BK_WRAP: next_addr = step_wrap(cur_addr, size, wrap_mask);
      default: next_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 9,
  parameter int MAX_SIZE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  beats_i,
  input  logic [1:0]        kind_i,
  input  logic              beat_ready_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [LEN_W-1:0]  beat_idx_o,
  output logic              beat_last_o,
  output logic              err_o
);

  burst_kind_e       req_kind;
  logic [ADDR_W-1:0] req_mask;
  logic              req_legal;
  logic              bad_align, bad_count, bad_field;

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  last_idx_q;
  logic [2:0]        size_q;
  burst_kind_e       kind_q;
  logic [ADDR_W-1:0] mask_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_next;

  // Named internal events.
  logic accept_ev, reject_ev, beat_fire, final_fire;

  assign req_kind   = burst_kind_e'(kind_i);
  assign accept_ev  = start_i && !busy_q && req_legal;
  assign reject_ev  = start_i && !busy_q && !req_legal;
  assign beat_fire  = busy_q && beat_ready_i;
  assign final_fire = beat_fire && (idx_q == last_idx_q);

  burst_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SIZE(MAX_SIZE)) u_check (
    .start_addr (start_addr_i),
    .size       (size_i),
    .beats      (beats_i),
    .kind       (req_kind),
    .wrap_mask  (req_mask),
    .legal      (req_legal),
    .bad_align  (bad_align),
    .bad_count  (bad_count),
    .bad_field  (bad_field)
  );

  burst_next #(.ADDR_W(ADDR_W)) u_next (
    .cur_addr  (addr_q),
    .size      (size_q),
    .kind      (kind_q),
    .wrap_mask (mask_q),
    .next_addr (addr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      addr_q     <= '0;
      idx_q      <= '0;
      last_idx_q <= '0;
      size_q     <= '0;
      kind_q     <= BK_FIXED;
      mask_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= reject_ev;
      if (accept_ev) begin
        busy_q     <= 1'b1;
        addr_q     <= start_addr_i;
        idx_q      <= '0;
        last_idx_q <= beats_i - LEN_W'(1);
        size_q     <= size_i;
        kind_q     <= req_kind;
        mask_q     <= req_mask;
      end else if (final_fire) begin
        busy_q <= 1'b0;
      end else if (beat_fire) begin
        addr_q <= addr_next;
        idx_q  <= idx_q + LEN_W'(1);
      end
    end
  end

  assign beat_valid_o = busy_q;
  assign beat_addr_o  = addr_q;
  assign beat_idx_o   = idx_q;
  assign beat_last_o  = busy_q && (idx_q == last_idx_q);
  assign err_o        = err_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!beat_valid_o && !err_o));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_addr_o) && $stable(beat_idx_o)));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last_o) |=> (beat_idx_o == $past(beat_idx_o) + LEN_W'(1)));

  // R8
  drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && beat_last_o) |=> (!beat_valid_o || $past(start_i)));

  // R9
  err_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(start_i) && !beat_valid_o));

  // R4
  fixed_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last_o && kind_q == BK_FIXED) |=> $stable(beat_addr_o));

  // R3
  incr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && kind_q == BK_INCR && beat_idx_o != '0) |->
      ((beat_addr_o & ((ADDR_W'(1) << size_q) - ADDR_W'(1))) == '0));

  // R5
  wrap_container_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last_o && kind_q == BK_WRAP) |=>
      (((beat_addr_o ^ $past(beat_addr_o)) & ~mask_q) == '0));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && beat_valid_o && !beat_fire) |=> $stable(beat_addr_o));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic [2:0]        size_i;
  logic [LEN_W-1:0]  beats_i;
  logic [1:0]        kind_i;
  logic              beat_ready_i;
  logic              beat_valid_o;
  logic [ADDR_W-1:0] beat_addr_o;
  logic [LEN_W-1:0]  beat_idx_o;
  logic              beat_last_o;
  logic              err_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen i_burst_addr_gen (
    .clk, .rst_n, .start_i, .start_addr_i, .size_i, .beats_i, .kind_i,
    .beat_ready_i, .beat_valid_o, .beat_addr_o, .beat_idx_o, .beat_last_o, .err_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the address rules, arithmetic in 64 bits.
  function automatic longint model_addr(longint st, int sz, int cnt, int kd, int i);
    longint b, span, base;
    b = longint'(1) << sz;
    case (kd)
      0: return st;
      1: return (i == 0) ? st : (((st / b) * b + i * b) % (longint'(1) << 32));
      default: begin
        span = b * cnt;
        base = (st / span) * span;
        return base + ((st - base + i * b) % span);
      end
    endcase
  endfunction

  task automatic request(longint st, int sz, int cnt, int kd);
    @(negedge clk);
    start_i      = 1'b1;
    start_addr_i = ADDR_W'(st);
    size_i       = 3'(sz);
    beats_i      = LEN_W'(cnt);
    kind_i       = 2'(kd);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Runs a whole burst and checks each presented beat against the model.
  task automatic run_burst(string req, longint st, int sz, int cnt, int kd,
                           bit stall, bit use_incr_model);
    int i = 0;
    int cyc = 0;
    bit rdy;
    longint exp;
    request(st, sz, cnt, kd);
    check(beat_valid_o && beat_idx_o == 0 && beat_addr_o == ADDR_W'(st), "R2",
          "first beat", beat_addr_o, st);
    while (i < cnt && cyc < 4000) begin
      rdy = !stall || (cyc % 3 != 1);
      beat_ready_i = rdy;
      exp = model_addr(st, sz, cnt, use_incr_model ? 1 : kd, i);
      check(beat_valid_o && beat_addr_o == ADDR_W'(exp),
            (!rdy) ? "R7" : req, "beat address", beat_addr_o, exp);
      check(beat_idx_o == LEN_W'(i) && beat_last_o == (i == cnt - 1), "R8",
            "index/last", {beat_idx_o, beat_last_o}, {LEN_W'(i), (i == cnt - 1)});
      @(negedge clk);
      if (rdy) i++;
      cyc++;
    end
    beat_ready_i = 1'b0;
    check(!beat_valid_o, "R8", "valid after final beat", beat_valid_o, 0);
  endtask

  task automatic expect_reject(string req, longint st, int sz, int cnt, int kd);
    request(st, sz, cnt, kd);
    check(err_o && !beat_valid_o, req, "error pulse", {err_o, beat_valid_o}, 2'b10);
    @(negedge clk);
    check(!err_o && !beat_valid_o, req, "pulse ends, no beat", {err_o, beat_valid_o}, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 1'b0; beat_ready_i = 1'b0;
    start_addr_i = '0; size_i = '0; beats_i = '0; kind_i = '0;
    repeat (3) @(negedge clk);
    check(!beat_valid_o && !beat_last_o && !err_o, "R1", "in reset",
          {beat_valid_o, beat_last_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid_o && !beat_last_o && !err_o, "R1", "after reset",
          {beat_valid_o, beat_last_o, err_o}, 0);
  endtask

  task automatic test_busy_start();
    request(32'h200, 2, 4, 1);
    beat_ready_i = 1'b1;
    @(negedge clk);
    beat_ready_i = 1'b0;
    start_i = 1'b1; start_addr_i = 32'h9000; size_i = 3'd0;
    beats_i = LEN_W'(2); kind_i = 2'b00;
    @(negedge clk);
    start_i = 1'b0;
    check(beat_valid_o && beat_addr_o == 32'h204 && beat_idx_o == 1, "R12",
          "running burst kept", beat_addr_o, 32'h204);
    beat_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    beat_ready_i = 1'b0;
    check(!beat_valid_o && !err_o, "R12", "burst ended, no new one",
          {beat_valid_o, err_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    test_reset();
    run_burst("R3", 32'h13, 2, 4, 1, 1'b0, 1'b0);
    run_burst("R3", 32'h105, 3, 5, 1, 1'b1, 1'b0);
    run_burst("R3", 32'hFFFF_FFF9, 2, 3, 1, 1'b0, 1'b0);
    run_burst("R4", 32'h7, 1, 3, 0, 1'b1, 1'b0);
    run_burst("R5", 32'h18, 2, 4, 2, 1'b0, 1'b0);
    run_burst("R5", 32'h1F8, 3, 16, 2, 1'b1, 1'b0);
    run_burst("R5", 32'h46, 1, 2, 2, 1'b0, 1'b0);
    run_burst("R6", 32'h10, 2, 4, 2, 1'b0, 1'b1);
    run_burst("R8", 32'h33, 0, 1, 1, 1'b0, 1'b0);
    expect_reject("R9", 32'h19, 2, 4, 2);
    expect_reject("R10", 32'h20, 2, 3, 2);
    expect_reject("R10", 32'h0, 0, 32, 2);
    expect_reject("R11", 32'h0, 4, 4, 1);
    expect_reject("R11", 32'h0, 2, 0, 1);
    expect_reject("R11", 32'h0, 2, 4, 3);
    test_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule